// File: doc/BRIEF.md
# OTP Packet Read Controller

This block sits between a 32-bit register bus and a one-time-programmable word array. It lets software fetch one variable-length packet at a time. The array holds packets back to back. Each packet is a single header word followed by a payload. The header's size field `S` (bits 15:8) gives a payload of `S+1` words, so the next header sits `S+2` words after the current one. Software writes a word address into the upper half of the mode register and then sets the read command bit in the control register. The controller walks the headers from word 0 until it finds the packet whose range covers that address. It then copies the header and the payload into local buffers and drops its busy flag.

After the copy, software reads the header through the header register. To read the payload, it writes a start index into the index register and then reads the data register repeatedly. Each data read returns one payload word and moves the index forward. The requested address only selects a packet; it never maps directly onto a payload word. The walker has five states. IDLE waits for a command. FETCH issues a header read. CHECK evaluates that header and then either advances to the next header (CHECK->FETCH), accepts the packet (CHECK->COPY) or rejects the request (CHECK->MISS). COPY streams the payload words into the buffer and returns to IDLE when the last word is stored (COPY->IDLE). MISS clears the buffers (MISS->IDLE). FETCH goes to MISS when the walk position has run past the end of the array.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset, the status, header, data and mode registers all read as zero.
- R2: The mode register (offset 0x04) stores all 32 written bits and returns them on read. Its bits 31:16 are the target word address of the next packet read.
- R3: A write to the control register (offset 0x00) with bit 6 set, while the controller is idle, starts a packet read. The busy flag is high from the next clock cycle until the read finishes.
- R4: Bit 6 of the status register (offset 0x0C) returns the busy flag. All other status bits read as zero.
- R5: A header's bits 15:8 hold a size `S`, and its packet spans `S+2` words, with the next header directly after it. Any target inside a packet's span selects that whole packet.
- R6: After a successful read, the header register (offset 0x20) returns the selected packet's header word.
- R7: A write to the index register (offset 0x08) sets the payload index. Each read of the data register (offset 0x24) returns payload word number `index` and then increments the index by one.
- R8: Data register reads at an index of `S+1` or higher return zero.
- R9: A header word of all zeros ends the packet list. A target past the last packet, or a packet that would run past the array end, clears busy and leaves the header at zero and all data reads at zero.
- R10: A read command issued while busy is ignored. The running read completes for the target latched when it started.
- R11: The array port makes at most one access per cycle with one cycle of read latency. It is active only while busy and never addresses a word beyond the array depth.
- R12: Register bus reads return their data on `bus_rdata` one clock cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| arr_rd | output | 1 | Array read enable |
| arr_addr | output | 12 | Array word address |
| arr_rdata | input | 32 | Array read data, one cycle after arr_rd |

## Verification
Suppose the walker skips a packet boundary wrongly, by an off-by-one in the `S+2` step. Software would then see the neighbouring header in the header register as soon as busy drops, and the target-at-last-word cases expose this. A wrong payload count or index stepping shows up on the very next data read: a buffered word appears where zero is expected, or zero appears too early. If a second command were wrongly accepted while busy, the latched target would change in the following cycle, and a different header would be read back afterwards. Status reads taken in the cycle right after a command show whether busy rises on time.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_IDX  = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_HDR  = 8'h20;
    localparam logic [7:0] OFS_DATA = 8'h24;
    localparam int CMD_BIT  = 6;
    localparam int BUSY_BIT = 6;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH,
        W_CHECK,
        W_COPY,
        W_MISS
    } walk_state_t;
endpackage

// File: rtl/otp_regif.sv
module otp_regif
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 8,
    localparam int IDX_W = SIZE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic [31:0]       hdr_word,
    input  logic [31:0]       pay_word,
    output logic              start,
    output logic [ADDR_W-1:0] target,
    output logic              idx_wr,
    output logic [IDX_W-1:0]  idx_val,
    output logic              data_rd
);
    logic [31:0] mode_q;
    logic [31:0] rd_mux;

    assign start   = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CMD_BIT];
    assign target  = mode_q[31:32-ADDR_W];
    assign idx_wr  = bus_wr && (bus_addr == OFS_IDX);
    assign idx_val = bus_wdata[IDX_W-1:0];
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (bus_wr && (bus_addr == OFS_MODE)) begin
            mode_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_MODE: rd_mux = mode_q;
            OFS_STAT: rd_mux[BUSY_BIT] = busy;
            OFS_HDR:  rd_mux = hdr_word;
            OFS_DATA: rd_mux = pay_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/otp_walker.sv
module otp_walker
    import otp_pkg::*;
#(
    parameter int DEPTH  = 2816,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = SIZE_W + 1,
    localparam int POS_W = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] target,
    output logic              arr_rd,
    output logic [AW-1:0]     arr_addr,
    input  logic [31:0]       arr_rdata,
    output logic              busy,
    output logic [31:0]       hdr_word,
    output logic [IDX_W-1:0]  plen,
    output logic              buf_we,
    output logic [SIZE_W-1:0] buf_waddr,
    output logic [31:0]       buf_wdata,
    output logic [ADDR_W-1:0] tgt_held
);
    walk_state_t state_q, state_d;

    logic [POS_W-1:0]  pos_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [31:0]       hdr_q;
    logic [IDX_W-1:0]  plen_q;
    logic [IDX_W-1:0]  iss_q;
    logic [IDX_W-1:0]  cap_q;
    logic              vq;

    logic [SIZE_W-1:0] sz;
    logic [POS_W-1:0]  nxt_pos;
    logic [POS_W-1:0]  tail_pos;
    logic [POS_W-1:0]  cp_addr;
    logic              hit, fits, pos_ok, can_iss, last_cap, hdr_blank;

    assign sz        = arr_rdata[SIZE_W+7:8];
    assign nxt_pos   = pos_q + POS_W'(sz) + POS_W'(2);
    assign tail_pos  = pos_q + POS_W'(sz) + POS_W'(1);
    assign cp_addr   = pos_q + POS_W'(1) + POS_W'(iss_q);
    assign hit       = POS_W'(tgt_q) < nxt_pos;
    assign fits      = tail_pos < POS_W'(DEPTH);
    assign pos_ok    = pos_q < POS_W'(DEPTH);
    assign can_iss   = iss_q < plen_q;
    assign last_cap  = vq && (cap_q == plen_q - IDX_W'(1));
    assign hdr_blank = (arr_rdata == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (start) state_d = W_FETCH;
            W_FETCH: state_d = pos_ok ? W_CHECK : W_MISS;
            W_CHECK: begin
                if (hdr_blank)   state_d = W_MISS;
                else if (!hit)   state_d = W_FETCH;
                else if (fits)   state_d = W_COPY;
                else             state_d = W_MISS;
            end
            W_COPY:  if (last_cap) state_d = W_IDLE;
            W_MISS:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        arr_rd    = 1'b0;
        arr_addr  = '0;
        buf_we    = 1'b0;
        unique case (state_q)
            W_FETCH: begin
                arr_rd   = pos_ok;
                arr_addr = pos_ok ? pos_q[AW-1:0] : '0;
            end
            W_COPY: begin
                arr_rd   = can_iss;
                arr_addr = can_iss ? cp_addr[AW-1:0] : '0;
                buf_we   = vq;
            end
            default: ;
        endcase
        buf_waddr = cap_q[SIZE_W-1:0];
        buf_wdata = arr_rdata;
        busy      = (state_q != W_IDLE);
        hdr_word  = hdr_q;
        plen      = plen_q;
        tgt_held  = tgt_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            tgt_q  <= '0;
            hdr_q  <= '0;
            plen_q <= '0;
            iss_q  <= '0;
            cap_q  <= '0;
            vq     <= 1'b0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (start) begin
                        pos_q <= '0;
                        tgt_q <= target;
                    end
                end
                W_CHECK: begin
                    if (!hdr_blank && hit && fits) begin
                        hdr_q  <= arr_rdata;
                        plen_q <= IDX_W'(sz) + IDX_W'(1);
                        iss_q  <= '0;
                        cap_q  <= '0;
                        vq     <= 1'b0;
                    end else if (!hdr_blank && !hit) begin
                        pos_q <= nxt_pos;
                    end
                end
                W_COPY: begin
                    if (can_iss) iss_q <= iss_q + IDX_W'(1);
                    vq <= can_iss;
                    if (vq) cap_q <= cap_q + IDX_W'(1);
                end
                W_MISS: begin
                    hdr_q  <= '0;
                    plen_q <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/otp_paybuf.sv
module otp_paybuf #(
    parameter int SIZE_W = 8,
    localparam int IDX_W = SIZE_W + 1,
    localparam int PMAX  = 1 << SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SIZE_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [IDX_W-1:0]  plen,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic              data_rd,
    output logic [31:0]       rd_word,
    output logic [IDX_W-1:0]  idx
);
    logic [31:0]      store [PMAX];
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= idx_val;
        end else if (data_rd && (idx_q != '1)) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign rd_word = (idx_q < plen) ? store[idx_q[SIZE_W-1:0]] : '0;
    assign idx     = idx_q;
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader #(
    parameter int DEPTH  = 2816,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = SIZE_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          arr_rd,
    output logic [AW-1:0] arr_addr,
    input  logic [31:0]   arr_rdata
);
    logic              start_w, busy_w, idx_wr_w, data_rd_w, buf_we_w;
    logic [ADDR_W-1:0] target_w, tgt_held_w;
    logic [IDX_W-1:0]  idx_val_w, plen_w, idx_w;
    logic [31:0]       hdr_w, pay_w, buf_wdata_w;
    logic [SIZE_W-1:0] buf_waddr_w;

    otp_regif #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy_w), .hdr_word(hdr_w), .pay_word(pay_w),
        .start(start_w), .target(target_w),
        .idx_wr(idx_wr_w), .idx_val(idx_val_w), .data_rd(data_rd_w)
    );

    otp_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .target(target_w),
        .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .busy(busy_w), .hdr_word(hdr_w), .plen(plen_w),
        .buf_we(buf_we_w), .buf_waddr(buf_waddr_w), .buf_wdata(buf_wdata_w),
        .tgt_held(tgt_held_w)
    );

    otp_paybuf #(.SIZE_W(SIZE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .we(buf_we_w), .waddr(buf_waddr_w), .wdata(buf_wdata_w),
        .plen(plen_w), .idx_wr(idx_wr_w), .idx_val(idx_val_w),
        .data_rd(data_rd_w), .rd_word(pay_w), .idx(idx_w)
    );
endmodule

// File: rtl/otp_pkt_reader_chk.sv
module otp_pkt_reader_chk
    import otp_pkg::*;
#(
    parameter int DEPTH  = 2816,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = SIZE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              start,
    input logic              busy,
    input logic              arr_rd,
    input logic [AW-1:0]     arr_addr,
    input logic [ADDR_W-1:0] tgt,
    input logic [IDX_W-1:0]  idx,
    input logic [IDX_W-1:0]  plen
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(tgt)); // R10

    AST_ARR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |-> (32'(arr_addr) < DEPTH)); // R11

    AST_ARR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |-> busy); // R11

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFS_DATA) && (idx >= plen)) |=> (bus_rdata == '0)); // R8

    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFS_STAT)) |=> (bus_rdata[BUSY_BIT] == $past(busy))); // R4
endmodule

bind otp_pkt_reader otp_pkt_reader_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .start(start_w), .busy(busy_w),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .tgt(tgt_held_w),
    .idx(idx_w), .plen(plen_w)
);

// File: tb/sim_otp_pkt_reader.sv
module sim_otp_pkt_reader;
    localparam int DEPTH = 2816;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          arr_rd;
    logic [AW-1:0] arr_addr;
    logic [31:0]   arr_rdata = '0;

    int checks = 0, failures = 0, range_viol = 0;
    logic chk_en = 1'b0, mon_v = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mem [DEPTH];

    always #2 clk = ~clk;

    otp_pkt_reader u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    // array model: one cycle read latency
    always @(posedge clk) if (arr_rd) arr_rdata <= mem[arr_addr];
    always @(negedge clk) if (arr_rd && (32'(arr_addr) >= DEPTH)) range_viol++;

    // monitor: compares each scored read one cycle after issue (R12)
    always @(posedge clk) mon_v <= chk_en;
    always @(negedge clk) begin
        if (mon_v) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    function automatic logic [31:0] hdr(input logic [7:0] sz, input logic [7:0] id);
        return {8'h5A, id, sz, 8'h11};
    endfunction
    function automatic logic [31:0] pw(input int a);
        return 32'hBEEF_0000 + 32'(a);
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a; chk_en = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; chk_en = 1'b0;
    endtask

    task automatic read_raw(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 2000; n++) begin
            read_raw(8'h0C, s);
            if (!s[6]) break;
        end
    endtask

    task automatic pkt_read(input logic [15:0] tgt);
        bus_write(8'h04, {tgt, 16'h0});
        bus_write(8'h00, 32'h40);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        // packet 0 at 0, size 2 (3 payload words), next at 4
        mem[0] = hdr(8'd2, 8'hA0);
        for (int i = 1; i <= 3; i++) mem[i] = pw(i);
        // packet 1 at 4, size 0, next at 6
        mem[4] = hdr(8'd0, 8'hA1);
        mem[5] = pw(5);
        // packet 2 at 6, size 5, next at 13 (blank header ends list)
        mem[6] = hdr(8'd5, 8'hA2);
        for (int i = 7; i <= 12; i++) mem[i] = pw(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        expect_rd(8'h0C, 32'h0, "R1 status");
        expect_rd(8'h20, 32'h0, "R1 header");
        expect_rd(8'h24, 32'h0, "R1 data");
        expect_rd(8'h04, 32'h0, "R1 mode");

        bus_write(8'h04, 32'h1234_ABCD);
        expect_rd(8'h04, 32'h1234_ABCD, "R2 mode readback");

        // target 0 -> packet 0
        bus_write(8'h04, 32'h0000_0000);
        bus_write(8'h00, 32'h40);
        expect_rd(8'h0C, 32'h40, "R3 R4 busy after command");
        wait_idle();
        expect_rd(8'h0C, 32'h0, "R4 idle status");
        expect_rd(8'h20, hdr(8'd2, 8'hA0), "R6 R12 header pkt0");
        bus_write(8'h08, 32'h0);
        expect_rd(8'h24, pw(1), "R7 word0");
        expect_rd(8'h24, pw(2), "R7 word1");
        expect_rd(8'h24, pw(3), "R7 word2");
        expect_rd(8'h24, 32'h0, "R8 past end");
        expect_rd(8'h24, 32'h0, "R8 past end again");

        // target 5 -> packet 1 (span 4..5)
        pkt_read(16'd5);
        expect_rd(8'h20, hdr(8'd0, 8'hA1), "R5 header pkt1");
        bus_write(8'h08, 32'h0);
        expect_rd(8'h24, pw(5), "R7 pkt1 word0");
        expect_rd(8'h24, 32'h0, "R8 pkt1 end");

        // target 12 -> packet 2 (last word of its span)
        pkt_read(16'd12);
        expect_rd(8'h20, hdr(8'd5, 8'hA2), "R5 header pkt2");
        bus_write(8'h08, 32'd3);
        expect_rd(8'h24, pw(10), "R7 index 3");
        expect_rd(8'h24, pw(11), "R7 index 4");
        expect_rd(8'h24, pw(12), "R7 index 5");
        expect_rd(8'h24, 32'h0, "R8 index 6");

        // target 3 -> still packet 0
        pkt_read(16'd3);
        expect_rd(8'h20, hdr(8'd2, 8'hA0), "R5 header pkt0 via 3");

        // miss: blank header at 13
        pkt_read(16'd13);
        expect_rd(8'h20, 32'h0, "R9 header after miss");
        bus_write(8'h08, 32'h0);
        expect_rd(8'h24, 32'h0, "R9 data after miss");
        pkt_read(16'hFFFF);
        expect_rd(8'h20, 32'h0, "R9 far target");
        expect_rd(8'h0C, 32'h0, "R9 busy cleared");

        // command while busy ignored
        bus_write(8'h04, {16'd6, 16'h0});
        bus_write(8'h00, 32'h40);
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, 32'h40);
        wait_idle();
        expect_rd(8'h20, hdr(8'd5, 8'hA2), "R10 header of first command");
        bus_write(8'h08, 32'h0);
        expect_rd(8'h24, pw(7), "R10 payload of first command");

        repeat (3) @(negedge clk);
        checks++;
        if (range_viol != 0) begin
            failures++;
            $display("FAIL R11: got %0d out-of-range accesses expected 0", range_viol);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule